// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Unit

This unit carries out the second byte of the prefixed bit-manipulation instruction group of an 8-bit CPU. It works on one byte operand. It takes the opcode byte, the operand byte and the current flags. It returns the result byte, a write-back enable and the new flags. It also hands back the operand selector, so the surrounding datapath knows whether the result belongs in a register or in memory addressed by HL. Register-file and memory access stay outside the unit.

The opcode is decoded from three fields:
- The two top bits choose the group: rotate/shift/swap, test bit, clear bit or set bit.
- The middle three bits name either the shift operation or the bit index.
- The low three bits name the operand.

Input and output are valid/ready streams with one register stage between them. A memory operand can therefore arrive some cycles after the opcode was fetched, and a busy consumer can stall the result.

Back-pressure rules:
- An item is taken on a clock edge where `in_valid` and `in_ready` are both high.
- A result is handed off on a clock edge where `out_valid` and `out_ready` are both high.
- `in_ready` is low exactly while a result is waiting that will not be taken this cycle. A new item can therefore be taken in the same cycle as the previous result leaves.
- While a result waits, every output holds its value.

Top module: `bitop_unit`

## Requirements
- R1: An accepted item (`in_valid` and `in_ready` high at a clock edge) shows up on the outputs with `out_valid` high right after that edge, one cycle of latency. Back-to-back items stream at one per cycle while `out_ready` stays high.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is low, no new item is taken, and `out_result`, `out_flags`, `out_wb` and `out_sel` hold their values.
- R3: The opcode fields are: bits 7:6 the group, bits 5:3 the operation or bit index, bits 2:0 the operand selector. `out_sel` returns bits 2:0 of the accepted opcode; its code 110 means memory at HL, and the codes 000..111 otherwise stand for B, C, D, E, H, L, (HL), A.
- R4: In group 00, operation 000 rotates left and copies bit 7 into bit 0 and into carry. Operation 001 rotates right and copies bit 0 into bit 7 and into carry. Operation 010 rotates left through carry, and operation 011 rotates right through carry; in both, the bit shifted out becomes the new carry.
- R5: In group 00, operation 100 shifts left and fills bit 0 with 0. Operation 101 shifts right and keeps bit 7. Operation 111 shifts right and fills bit 7 with 0. In each case the bit shifted out becomes carry.
- R6: In group 00, operation 110 exchanges the two nibbles of the operand and clears carry.
- R7: Flags are packed as `out_flags`/`in_flags` bit 3 zero, bit 2 subtract, bit 1 half-carry, bit 0 carry. For group 00, zero is set exactly when the result is 0, subtract and half-carry are 0, and `out_wb` is 1.
- R8: Group 01 (test bit):
  - zero is set to the inverse of the operand bit named by bits 5:3;
  - subtract is cleared and half-carry is set;
  - carry is copied from `in_flags`;
  - `out_wb` is 0 and `out_result` equals the operand.
- R9: Group 10 clears, and group 11 sets, only the operand bit named by bits 5:3. `out_flags` equals `in_flags` and `out_wb` is 1.
- R10: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Unit can take an item this cycle |
| in_opcode | input | 8 | Second opcode byte |
| in_operand | input | 8 | Operand byte |
| in_flags | input | 4 | Current flags {Z,N,H,C} |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Result byte |
| out_flags | output | 4 | New flags {Z,N,H,C} |
| out_wb | output | 1 | Result is to be written back |
| out_sel | output | 3 | Operand selector, 110 = memory at HL |

## Verification
Two things can happen in the same cycle: the hand-off of one result and the acceptance of the next item.

The bench provokes this with a streaming phase in which a fresh item is presented on every cycle while `out_ready` stays high. Each result must appear exactly one cycle after its own item was taken, with `in_ready` never dropping.

The serial sweep covers every opcode byte against eight operand patterns, and at intervals it holds `out_ready` low while presenting a spoiler item. In that case the bench judges that `in_ready` is low, that the waiting result does not change, and that the spoiler never appears on the outputs.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    SH_ROL_WRAP  = 3'b000,
    SH_ROR_WRAP  = 3'b001,
    SH_ROL_CARRY = 3'b010,
    SH_ROR_CARRY = 3'b011,
    SH_SHL_ZERO  = 3'b100,
    SH_SHR_SIGN  = 3'b101,
    SH_NIBBLE_X  = 3'b110,
    SH_SHR_ZERO  = 3'b111
  } shop_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  localparam logic [2:0] SEL_MEM_HL = 3'b110;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [7:0] opcode,
  output grp_e       grp,
  output logic [2:0] sub,
  output logic [2:0] sel
);
  always_comb begin
    grp = grp_e'(opcode[7:6]);
    sub = opcode[5:3];
    sel = opcode[2:0];
  end
endmodule

// File: rtl/bitop_shift.sv
module bitop_shift
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] d,
  input  logic              cin,
  input  logic [2:0]        sub,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    res  = d;
    cout = 1'b0;
    case (shop_e'(sub))
      SH_ROL_WRAP:  begin res = {d[DATA_W-2:0], d[DATA_W-1]}; cout = d[DATA_W-1]; end
      SH_ROR_WRAP:  begin res = {d[0], d[DATA_W-1:1]};        cout = d[0];        end
      SH_ROL_CARRY: begin res = {d[DATA_W-2:0], cin};         cout = d[DATA_W-1]; end
      SH_ROR_CARRY: begin res = {cin, d[DATA_W-1:1]};         cout = d[0];        end
      SH_SHL_ZERO:  begin res = {d[DATA_W-2:0], 1'b0};        cout = d[DATA_W-1]; end
      SH_SHR_SIGN:  begin res = {d[DATA_W-1], d[DATA_W-1:1]}; cout = d[0];        end
      SH_NIBBLE_X:  begin res = {d[HALF-1:0], d[DATA_W-1:HALF]}; cout = 1'b0;     end
      SH_SHR_ZERO:  begin res = {1'b0, d[DATA_W-1:1]};        cout = d[0];        end
      default:      begin res = d; cout = 1'b0; end
    endcase
  end
endmodule

// File: rtl/bitop_bitwise.sv
module bitop_bitwise #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] d,
  input  logic [IDX_W-1:0]  idx,
  input  logic              set_not_clr,
  output logic [DATA_W-1:0] res,
  output logic              bit_val
);
  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (idx == IDX_W'(i));
  end

  always_comb begin
    bit_val = |(d & mask);
    res     = set_not_clr ? (d | mask) : (d & ~mask);
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [3:0]        in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [3:0]        out_flags,
  output logic              out_wb,
  output logic [2:0]        out_sel
);
  localparam int IDX_W = $clog2(DATA_W);

  grp_e              grp;
  logic [2:0]        sub;
  logic [2:0]        sel;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cout;
  logic [DATA_W-1:0] bw_res;
  logic              bw_bit;
  flags_t            f_in;
  flags_t            f_nx;
  logic [DATA_W-1:0] res_nx;
  logic              wb_nx;
  logic              take;

  bitop_decode u_dec (
    .opcode (in_opcode),
    .grp    (grp),
    .sub    (sub),
    .sel    (sel)
  );

  bitop_shift #(.DATA_W(DATA_W)) u_shift (
    .d    (in_operand),
    .cin  (in_flags[0]),
    .sub  (sub),
    .res  (sh_res),
    .cout (sh_cout)
  );

  bitop_bitwise #(.DATA_W(DATA_W)) u_bits (
    .d           (in_operand),
    .idx         (sub[IDX_W-1:0]),
    .set_not_clr (grp == GRP_SET),
    .res         (bw_res),
    .bit_val     (bw_bit)
  );

  assign f_in = flags_t'(in_flags);

  always_comb begin
    res_nx = in_operand;
    f_nx   = f_in;
    wb_nx  = 1'b0;
    case (grp)
      GRP_SHIFT: begin
        res_nx = sh_res;
        f_nx   = '{z: (sh_res == '0), n: 1'b0, h: 1'b0, c: sh_cout};
        wb_nx  = 1'b1;
      end
      GRP_TEST: begin
        res_nx = in_operand;
        f_nx   = '{z: ~bw_bit, n: 1'b0, h: 1'b1, c: f_in.c};
        wb_nx  = 1'b0;
      end
      default: begin
        res_nx = bw_res;
        f_nx   = f_in;
        wb_nx  = 1'b1;
      end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_result <= '0;
      out_flags  <= '0;
      out_wb     <= 1'b0;
      out_sel    <= '0;
    end else if (take) begin
      out_result <= res_nx;
      out_flags  <= f_nx;
      out_wb     <= wb_nx;
      out_sel    <= sel;
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_opcode,
  input logic [7:0] in_operand,
  input logic [3:0] in_flags,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_result,
  input logic [3:0] out_flags,
  input logic       out_wb,
  input logic [2:0] out_sel
);
  logic take;
  assign take = in_valid && in_ready;

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_flags) && $stable(out_wb) && $stable(out_sel)));

  p_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_sel == $past(in_opcode[2:0])));

  p_shift_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_opcode[7:6] == 2'b00) |=>
      (out_wb && !out_flags[2] && !out_flags[1] && (out_flags[3] == (out_result == 8'h00))));

  p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_opcode[7:3] == 5'b00110) |=>
      (out_result == {$past(in_operand[3:0]), $past(in_operand[7:4])} && !out_flags[0]));

  p_test_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_opcode[7:6] == 2'b01) |=>
      (!out_wb && !out_flags[2] && out_flags[1] && out_flags[0] == $past(in_flags[0]) &&
       out_result == $past(in_operand)));

  p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_opcode[7:6] == 2'b11) |=>
      (out_wb && out_flags == $past(in_flags) &&
       out_result == ($past(in_operand) | (8'd1 << $past(in_opcode[5:3])))));

  p_reset_r10: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

bind bitop_unit bitop_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_opcode  (in_opcode),
  .in_operand (in_operand),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flags  (out_flags),
  .out_wb     (out_wb),
  .out_sel    (out_sel)
);

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_opcode = '0;
  logic [7:0] in_operand = '0;
  logic [3:0] in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [3:0] out_flags;
  logic       out_wb;
  logic [2:0] out_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bitop_unit u_bitop_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_operand(in_operand), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_flags(out_flags), .out_wb(out_wb), .out_sel(out_sel)
  );

  // expected {wb, flags[3:0], result[7:0]}
  function automatic logic [12:0] model(logic [7:0] op, logic [7:0] d, logic [3:0] f);
    logic [7:0] r;
    logic c;
    logic [2:0] k;
    k = op[5:3];
    r = d;
    c = 1'b0;
    case (op[7:6])
      2'b00: begin
        case (k)
          3'd0: begin c = d[7]; r = (d << 1) + {7'd0, d[7]}; end
          3'd1: begin c = d[0]; r = (d >> 1) + (d[0] ? 8'h80 : 8'h00); end
          3'd2: begin c = d[7]; r = (d << 1) + {7'd0, f[0]}; end
          3'd3: begin c = d[0]; r = (d >> 1) + (f[0] ? 8'h80 : 8'h00); end
          3'd4: begin c = d[7]; r = d << 1; end
          3'd5: begin c = d[0]; r = (d >> 1) + (d & 8'h80); end
          3'd6: begin c = 1'b0; r = (d << 4) + (d >> 4); end
          default: begin c = d[0]; r = d >> 1; end
        endcase
        return {1'b1, (r == 0), 1'b0, 1'b0, c, r};
      end
      2'b01: return {1'b0, ((d >> k) & 8'd1) == 0, 1'b0, 1'b1, f[0], d};
      2'b10: return {1'b1, f, d & ~(8'd1 << k)};
      default: return {1'b1, f, d | (8'd1 << k)};
    endcase
  endfunction

  function automatic logic [7:0] pattern(int k);
    case (k % 8)
      0: return 8'h00; 1: return 8'hFF; 2: return 8'h01; 3: return 8'h80;
      4: return 8'h0F; 5: return 8'hF0; 6: return 8'hA5; default: return 8'h5A;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] op);
    case (op[7:6])
      2'b00: begin
        if (op[5:3] == 3'd6) return "R6";
        else if (op[5:3] < 3'd4) return "R4";
        else return "R5";
      end
      2'b01: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out(logic [12:0] e, logic [2:0] sel, string req);
    check(out_valid === 1'b1, "R1", {31'd0, out_valid}, 32'd1);
    check(out_result === e[7:0], req, {24'd0, out_result}, {24'd0, e[7:0]});
    check(out_flags === e[11:8], "R7", {28'd0, out_flags}, {28'd0, e[11:8]});
    check(out_wb === e[12], req, {31'd0, out_wb}, {31'd0, e[12]});
    check(out_sel === sel, "R3", {29'd0, out_sel}, {29'd0, sel});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [12:0] e;
    logic [12:0] prev_e;
    logic [2:0]  prev_sel;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10", {31'd0, out_valid}, 32'd0);
    check(in_ready === 1'b1, "R10", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // serial sweep: every opcode byte, several operands and flag sets
    for (int op = 0; op < 256; op++) begin
      for (int k = 0; k < 8; k++) begin
        bit stall;
        logic [7:0] opv;
        logic [3:0] fl;
        opv = op[7:0];
        fl = {k[1], k[2], ~k[1], k[0] ^ op[0]};
        stall = ((op + k) % 5) == 0;
        @(negedge clk);
        in_valid = 1'b1; in_opcode = opv; in_operand = pattern(k + op); in_flags = fl;
        out_ready = !stall;
        e = model(opv, pattern(k + op), fl);
        @(negedge clk);
        check_out(e, opv[2:0], tag_of(opv));
        if (stall) begin
          in_opcode = ~opv; in_operand = ~pattern(k + op); in_flags = ~fl;
          check(in_ready === 1'b0, "R2", {31'd0, in_ready}, 32'd0);
          @(negedge clk);
          check_out(e, opv[2:0], "R2");
          in_valid = 1'b0;
          out_ready = 1'b1;
        end else begin
          in_valid = 1'b0;
        end
        @(negedge clk);
        check(out_valid === 1'b0, "R1", {31'd0, out_valid}, 32'd0);
      end
    end

    // streaming: hand-off and acceptance in the same cycle
    out_ready = 1'b1;
    prev_e = '0;
    prev_sel = '0;
    for (int i = 0; i < 96; i++) begin
      logic [7:0] opv;
      logic [3:0] fl;
      @(negedge clk);
      if (i > 0) begin
        check_out(prev_e, prev_sel, "R1");
        check(in_ready === 1'b1, "R1", {31'd0, in_ready}, 32'd1);
      end
      opv = 8'((i * 37 + 11) & 255);
      fl = 4'(i);
      in_valid = 1'b1; in_opcode = opv; in_operand = pattern(i * 3) ^ 8'(i); in_flags = fl;
      prev_e = model(opv, pattern(i * 3) ^ 8'(i), fl);
      prev_sel = opv[2:0];
    end
    @(negedge clk);
    check_out(prev_e, prev_sel, "R1");
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R1", {31'd0, out_valid}, 32'd0);

    // reset while a result waits
    out_ready = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R10", {31'd0, out_valid}, 32'd0);
    check(in_ready === 1'b1, "R10", {31'd0, in_ready}, 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule